// File: doc/BRIEF.md
# Sector ECC Correction Applier

This block sits behind a 4-bit-correcting ECC decoder for 512-byte storage sectors. It owns the sector's data bytes in an internal byte array. A host fills that array through a byte-wide load port and reads it back through a byte-wide read port. Once the decoder has finished, it presents a 3-bit count code and up to four pairs of error position and error pattern. A single start strobe tells the block to act on them.

The block first sorts the count code into one of three cases. The sector may be clean, it may be correctable with a known number of fixes, or it may be beyond repair. For a correctable sector, each reported position is turned into a byte offset by subtracting it from a fixed base of 519. The pattern is then XORed into that byte, one fix per clock as a read-modify-write. Positions that map outside the 512 data bytes land in the check-bit area and are stepped over. A one-cycle done pulse closes every request. The pass, uncorrectable and invalid-code flags stay valid from that pulse until the next accepted start.

Top module: `ecc_apply`

## Requirements
- R1: After reset, busy, done, pass, uncorr and bad_code are all 0.
- R2: While busy is 0, a cycle with ld_we=1 writes ld_data into byte ld_addr (0 to 511). rd_data always shows the current content of byte rd_addr, with no clock delay.
- R3: A start with err_code=4 changes no byte. done is high in the cycle right after the edge that samples start, with pass=1 and uncorr=0.
- R4: A start with err_code=7 changes no byte. done follows after one edge, with uncorr=1, bad_code=0 and pass=0.
- R5: A start with err_code=5 or 6 changes no byte. done follows after one edge, with uncorr=1 and bad_code=1.
- R6: A start with err_code=n, for n from 0 to 3, applies exactly the slots 0 to n. Slot s occupies bits [10s+9:10s] of err_addr and bits [8s+7:8s] of err_val. Slots above n are ignored, and the result is pass=1, uncorr=0, bad_code=0.
- R7: An applied slot XORs its err_val byte into byte offset 519 minus its err_addr. When several slots hit one byte, their patterns accumulate.
- R8: A slot whose offset is below 0 or above 511 (err_addr above 519 or below 8) leaves the buffer untouched. It still uses its cycle and does not change the pass result.
- R9: Fixes take one cycle each. For code n from 0 to 3, busy is high for n+1 cycles and done is high for exactly the one cycle after the last fix, n+1 edges after the sampling edge.
- R10: While busy is 1, the start strobe and load writes are ignored. They produce no extra done and no change to the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ld_we | input | 1 | Load-port write enable |
| ld_addr | input | 9 | Load-port byte offset |
| ld_data | input | 8 | Load-port byte value |
| rd_addr | input | 9 | Read-back byte offset |
| rd_data | output | 8 | Read-back byte value |
| start | input | 1 | Request to act on the decoder result |
| err_code | input | 3 | Error-count code from the decoder |
| err_addr | input | 40 | Four packed 10-bit error positions |
| err_val | input | 32 | Four packed 8-bit error patterns |
| busy | output | 1 | Fixes in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Sector good, clean or corrected |
| uncorr | output | 1 | Sector cannot be corrected |
| bad_code | output | 1 | Count code was 5 or 6 |

## Verification
The load port and the correction engine both write the same byte array, so a host write can arrive in a cycle where a fix is also due. The bench provokes this by raising ld_we with an inverted byte value, and start with a clean code, in the cycle right after a four-fix request is accepted. It judges the outcome by reading back the whole buffer against a reference model: the loaded byte must keep its old value. It also counts done pulses, so exactly one result must arrive, at the latency of the original request.

// File: rtl/ecc_apply_pkg.sv
package ecc_apply_pkg;

   typedef enum logic {
      ST_IDLE  = 1'b0,
      ST_APPLY = 1'b1
   } apply_st_e;

   typedef struct packed {
      logic pass;
      logic uncorr;
      logic bad_code;
   } apply_res_t;

endpackage

// File: rtl/ecc_code_dec.sv
module ecc_code_dec
   import ecc_apply_pkg::*;
#(
   parameter int CODE_W     = 3,
   parameter int CLEAN_CODE = 4,
   parameter int IDX_W      = 2
) (
   input  logic [CODE_W-1:0] code,
   output logic              do_apply,
   output logic [IDX_W-1:0]  last_idx,
   output apply_res_t        res
);
   localparam int FAIL_CODE = (1 << CODE_W) - 1;

   always_comb begin
      do_apply = 1'b0;
      last_idx = code[IDX_W-1:0];
      res      = '0;
      if (code == CODE_W'(CLEAN_CODE)) begin
         res.pass = 1'b1;
      end else if (code == CODE_W'(FAIL_CODE)) begin
         res.uncorr = 1'b1;
      end else if (code < CODE_W'(CLEAN_CODE)) begin
         do_apply = 1'b1;
         res.pass = 1'b1;
      end else begin
         res.uncorr   = 1'b1;
         res.bad_code = 1'b1;
      end
   end
endmodule

// File: rtl/ecc_off_calc.sv
module ecc_off_calc #(
   parameter int EADDR_W    = 10,
   parameter int OFF_W      = 9,
   parameter int OFF_BASE   = 519,
   parameter int DATA_BYTES = 512
) (
   input  logic [EADDR_W-1:0] err_addr,
   output logic [OFF_W-1:0]   off,
   output logic               in_range
);
   localparam int BASE_W = $clog2(OFF_BASE + 1);
   localparam int DW     = ((EADDR_W > BASE_W) ? EADDR_W : BASE_W) + 1;

   logic [DW-1:0] diff;

   // negative results wrap to huge unsigned values and fail the range test
   assign diff     = DW'(OFF_BASE) - DW'(err_addr);
   assign in_range = diff < DW'(DATA_BYTES);
   assign off      = diff[OFF_W-1:0];
endmodule

// File: rtl/ecc_byte_buf.sv
module ecc_byte_buf #(
   parameter int DEPTH  = 512,
   parameter int AW     = 9,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              ld_we,
   input  logic [AW-1:0]     ld_addr,
   input  logic [BYTE_W-1:0] ld_data,
   input  logic              fix_we,
   input  logic [AW-1:0]     fix_addr,
   input  logic [BYTE_W-1:0] fix_mask,
   input  logic [AW-1:0]     rd_addr,
   output logic [BYTE_W-1:0] rd_data
);
   logic [BYTE_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (fix_we) begin
         mem[fix_addr] <= mem[fix_addr] ^ fix_mask;
      end else if (ld_we) begin
         mem[ld_addr] <= ld_data;
      end
   end

   assign rd_data = mem[rd_addr];
endmodule

// File: rtl/ecc_apply.sv
module ecc_apply
   import ecc_apply_pkg::*;
#(
   parameter int DATA_BYTES = 512,
   parameter int SLOTS      = 4,
   parameter int EADDR_W    = 10,
   parameter int BYTE_W     = 8,
   parameter int CODE_W     = 3,
   parameter int OFF_BASE   = 519
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       ld_we,
   input  logic [$clog2(DATA_BYTES)-1:0] ld_addr,
   input  logic [BYTE_W-1:0]          ld_data,
   input  logic [$clog2(DATA_BYTES)-1:0] rd_addr,
   output logic [BYTE_W-1:0]          rd_data,
   input  logic                       start,
   input  logic [CODE_W-1:0]          err_code,
   input  logic [SLOTS*EADDR_W-1:0]   err_addr,
   input  logic [SLOTS*BYTE_W-1:0]    err_val,
   output logic                       busy,
   output logic                       done,
   output logic                       pass,
   output logic                       uncorr,
   output logic                       bad_code
);
   localparam int BUF_AW    = $clog2(DATA_BYTES);
   localparam int IDX_W     = (SLOTS > 1) ? $clog2(SLOTS) : 1;
   localparam int FAIL_CODE = (1 << CODE_W) - 1;

   // elaboration-time parameter checks
   if ((1 << BUF_AW) != DATA_BYTES) begin : g_chk_depth
      $error("DATA_BYTES must be a power of two");
   end
   if (SLOTS >= FAIL_CODE) begin : g_chk_slots
      $error("SLOTS must be below the failure code");
   end
   if ((1 << EADDR_W) <= OFF_BASE) begin : g_chk_eaddr
      $error("EADDR_W too narrow for OFF_BASE");
   end
   if (OFF_BASE < DATA_BYTES - 1) begin : g_chk_base
      $error("OFF_BASE must reach the last data byte");
   end

   apply_st_e         state;
   logic [IDX_W-1:0]  idx;
   logic [IDX_W-1:0]  last_q;
   logic              done_q;
   apply_res_t        res_q;

   logic [EADDR_W-1:0] addr_q [SLOTS];
   logic [BYTE_W-1:0]  val_q  [SLOTS];
   logic [BUF_AW-1:0]  off_s  [SLOTS];
   logic [SLOTS-1:0]   ok_s;

   logic              dec_apply;
   logic [IDX_W-1:0]  dec_last;
   apply_res_t        dec_res;

   logic              accept;
   logic              ld_ok;
   logic              fix_we;

   ecc_code_dec #(
      .CODE_W    (CODE_W),
      .CLEAN_CODE(SLOTS),
      .IDX_W     (IDX_W)
   ) u_dec (
      .code    (err_code),
      .do_apply(dec_apply),
      .last_idx(dec_last),
      .res     (dec_res)
   );

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      ecc_off_calc #(
         .EADDR_W   (EADDR_W),
         .OFF_W     (BUF_AW),
         .OFF_BASE  (OFF_BASE),
         .DATA_BYTES(DATA_BYTES)
      ) u_off (
         .err_addr(addr_q[s]),
         .off     (off_s[s]),
         .in_range(ok_s[s])
      );
   end

   assign accept = start && (state == ST_IDLE);
   assign ld_ok  = ld_we && (state == ST_IDLE);
   assign fix_we = (state == ST_APPLY) && ok_s[idx];

   ecc_byte_buf #(
      .DEPTH (DATA_BYTES),
      .AW    (BUF_AW),
      .BYTE_W(BYTE_W)
   ) u_buf (
      .clk     (clk),
      .ld_we   (ld_ok),
      .ld_addr (ld_addr),
      .ld_data (ld_data),
      .fix_we  (fix_we),
      .fix_addr(off_s[idx]),
      .fix_mask(val_q[idx]),
      .rd_addr (rd_addr),
      .rd_data (rd_data)
   );

   // captured error slots, no reset needed
   always_ff @(posedge clk) begin
      if (accept) begin
         for (int s = 0; s < SLOTS; s++) begin
            addr_q[s] <= err_addr[s*EADDR_W +: EADDR_W];
            val_q[s]  <= err_val[s*BYTE_W +: BYTE_W];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         idx    <= '0;
         last_q <= '0;
         done_q <= 1'b0;
         res_q  <= '0;
      end else begin
         done_q <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start) begin
                  res_q <= '0;
                  if (dec_apply) begin
                     state  <= ST_APPLY;
                     idx    <= '0;
                     last_q <= dec_last;
                  end else begin
                     done_q <= 1'b1;
                     res_q  <= dec_res;
                  end
               end
            end
            ST_APPLY: begin
               idx <= idx + IDX_W'(1);
               if (idx == last_q) begin
                  state  <= ST_IDLE;
                  done_q <= 1'b1;
                  res_q  <= '{pass: 1'b1, uncorr: 1'b0, bad_code: 1'b0};
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy     = (state == ST_APPLY);
   assign done     = done_q;
   assign pass     = res_q.pass;
   assign uncorr   = res_q.uncorr;
   assign bad_code = res_q.bad_code;
endmodule

// File: rtl/ecc_apply_chk.sv
module ecc_apply_chk #(
   parameter int CODE_W = 3,
   parameter int SLOTS  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [CODE_W-1:0] err_code,
   input logic              busy,
   input logic              done,
   input logic              pass,
   input logic              uncorr,
   input logic              bad_code
);
   localparam int FAIL_CODE = (1 << CODE_W) - 1;

   p_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && err_code == CODE_W'(SLOTS)) |=> (done && pass && !uncorr));

   p_fail_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && err_code == CODE_W'(FAIL_CODE)) |=> (done && uncorr && !bad_code && !pass));

   p_invalid_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && err_code > CODE_W'(SLOTS) && err_code != CODE_W'(FAIL_CODE))
      |=> (done && uncorr && bad_code));

   p_bad_sub_r5: assert property (@(posedge clk) disable iff (!rst_n)
      bad_code |-> uncorr);

   p_apply_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && err_code < CODE_W'(SLOTS)) |=> (busy && !done));

   p_busy_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (done && pass));

   p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> !done);

   p_flag_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($countones({pass, uncorr}) == 1));
endmodule

bind ecc_apply ecc_apply_chk #(
   .CODE_W(CODE_W),
   .SLOTS (SLOTS)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .err_code(err_code),
   .busy    (busy),
   .done    (done),
   .pass    (pass),
   .uncorr  (uncorr),
   .bad_code(bad_code)
);

// File: tb/tb_ecc_apply.sv
`timescale 1ns/1ps
module tb_ecc_apply;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ld_we = 1'b0;
   logic [8:0]  ld_addr = '0;
   logic [7:0]  ld_data = '0;
   logic [8:0]  rd_addr = '0;
   logic [7:0]  rd_data;
   logic        start = 1'b0;
   logic [2:0]  err_code = '0;
   logic [39:0] err_addr = '0;
   logic [31:0] err_val = '0;
   logic        busy, done, pass, uncorr, bad_code;

   always #2 clk = ~clk;

   ecc_apply dut (
      .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .start(start), .err_code(err_code),
      .err_addr(err_addr), .err_val(err_val), .busy(busy), .done(done),
      .pass(pass), .uncorr(uncorr), .bad_code(bad_code)
   );

   typedef struct {
      int    cyc;
      bit    pass;
      bit    unc;
      bit    bad;
      string tag;
   } exp_t;

   exp_t      exp_q[$];
   logic [7:0] refm [512];
   int        total = 0;
   int        nbad = 0;
   int        cyc = 0;
   bit        prev_done = 1'b0;
   bit        finished = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(bit ok, string req, string what, int act, int expv);
      total++;
      if (!ok) begin
         nbad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   // monitor: pops expected results as done pulses appear
   always @(negedge clk) begin
      if (rst_n) begin
         if (done) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R10", "unexpected done", 1, 0);
            end else begin
               exp_t it;
               it = exp_q.pop_front();
               chk(cyc == it.cyc, "R9", {"done cycle ", it.tag}, cyc, it.cyc);
               chk(pass == it.pass, it.tag, "pass", int'(pass), int'(it.pass));
               chk(uncorr == it.unc, it.tag, "uncorr", int'(uncorr), int'(it.unc));
               chk(bad_code == it.bad, it.tag, "bad_code", int'(bad_code), int'(it.bad));
            end
            if (prev_done) chk(1'b0, "R9", "done longer than one cycle", 1, 0);
         end
         prev_done <= done;
      end
   end

   task automatic load_all();
      for (int i = 0; i < 512; i++) begin
         @(negedge clk);
         ld_we   = 1'b1;
         ld_addr = 9'(i);
         ld_data = 8'((i * 37 + 5) & 255);
         refm[i] = 8'((i * 37 + 5) & 255);
      end
      @(negedge clk);
      ld_we = 1'b0;
   endtask

   task automatic verify(string tag);
      int mism = 0;
      for (int i = 0; i < 512; i++) begin
         rd_addr = 9'(i);
         #0.5;
         if (rd_data !== refm[i]) mism++;
      end
      chk(mism == 0, tag, "buffer mismatching bytes", mism, 0);
   endtask

   // reference model of the requirements
   task automatic ref_apply(int code, logic [39:0] a, logic [31:0] v);
      if (code < 4) begin
         for (int s = 0; s <= code; s++) begin
            int off = 519 - int'(a[s*10 +: 10]);
            if (off >= 0 && off < 512) refm[off] = refm[off] ^ v[s*8 +: 8];
         end
      end
   endtask

   function automatic exp_t make_exp(int code, string tag);
      exp_t it;
      it.tag = tag;
      it.pass = 1'b0; it.unc = 1'b0; it.bad = 1'b0;
      if (code == 4) begin
         it.pass = 1'b1; it.cyc = cyc + 1;
      end else if (code == 7) begin
         it.unc = 1'b1; it.cyc = cyc + 1;
      end else if (code > 4) begin
         it.unc = 1'b1; it.bad = 1'b1; it.cyc = cyc + 1;
      end else begin
         it.pass = 1'b1; it.cyc = cyc + code + 2;
      end
      return it;
   endfunction

   task automatic wait_empty();
      int guard = 0;
      while (exp_q.size() != 0 && guard < 50) begin
         @(negedge clk);
         guard++;
      end
      chk(exp_q.size() == 0, "R9", "missing done", exp_q.size(), 0);
      @(negedge clk);
   endtask

   task automatic run_case(int code, logic [39:0] a, logic [31:0] v, string tag);
      @(negedge clk);
      exp_q.push_back(make_exp(code, tag));
      ref_apply(code, a, v);
      start = 1'b1; err_code = 3'(code); err_addr = a; err_val = v;
      @(negedge clk);
      start = 1'b0;
      wait_empty();
      verify(tag);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         chk(1'b0, "watchdog", "run did not complete", 0, 1);
         $display("test done: total=%0d bad=%0d", total, nbad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(busy == 1'b0, "R1", "busy", int'(busy), 0);
      chk(done == 1'b0, "R1", "done", int'(done), 0);
      chk(pass == 1'b0, "R1", "pass", int'(pass), 0);
      chk(uncorr == 1'b0, "R1", "uncorr", int'(uncorr), 0);
      chk(bad_code == 1'b0, "R1", "bad_code", int'(bad_code), 0);

      // R2 load and read back
      load_all();
      verify("R2");

      // R3 clean code: in-range slots must be left alone
      run_case(4, {10'h100, 10'h107, 10'h050, 10'h0A0}, 32'hFFFF_FFFF, "R3");
      // R4 failure code
      run_case(7, {10'h100, 10'h107, 10'h050, 10'h0A0}, 32'h1234_5678, "R4");
      // R5 invalid codes
      run_case(5, {10'h100, 10'h107, 10'h050, 10'h0A0}, 32'hA5A5_A5A5, "R5");
      run_case(6, {10'h100, 10'h107, 10'h050, 10'h0A0}, 32'h5A5A_5A5A, "R5");
      // R7 single fix: offset 0x100
      run_case(0, {10'h050, 10'h060, 10'h070, 10'h107}, 32'h1111_115A, "R7");
      // R7 four fixes including the inclusive edges offset 511 and 0
      run_case(3, {10'h1F0, 10'h100, 10'h207, 10'h008}, 32'h3CFF_8001, "R7");
      // R6 slots above n ignored
      run_case(1, {10'h080, 10'h070, 10'h060, 10'h050}, 32'h4433_2211, "R6");
      // R7 two slots on the same byte accumulate
      run_case(1, {10'h000, 10'h000, 10'h0A0, 10'h0A0}, 32'h0000_330F, "R7");
      // R8 every slot out of range: 519, 512, negative, negative
      run_case(3, {10'h3FF, 10'h208, 10'h007, 10'h000}, 32'hFFEE_DDCC, "R8");

      // R10 load write and start arriving while fixes are in progress
      @(negedge clk);
      begin
         logic [39:0] a;
         logic [31:0] v;
         a = {10'h040, 10'h030, 10'h020, 10'h010};
         v = 32'h0807_0605;
         exp_q.push_back(make_exp(3, "R10"));
         ref_apply(3, a, v);
         start = 1'b1; err_code = 3'd3; err_addr = a; err_val = v;
         @(negedge clk);
         chk(busy == 1'b1, "R9", "busy after accepted start", int'(busy), 1);
         start = 1'b1; err_code = 3'd4;
         ld_we = 1'b1; ld_addr = 9'd100; ld_data = ~refm[100];
         @(negedge clk);
         start = 1'b0; ld_we = 1'b0;
         wait_empty();
         repeat (3) @(negedge clk);
         verify("R10");
      end

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, nbad);
      $finish;
   end
endmodule